// File: doc/BRIEF.md
# Backlight Dimmer with Inactivity Cut-off

This block drives the enable line of an LCD backlight. The line can be active only while the panel-power level and a software enable bit are both high. When it is active it is either held high, or it is dimmed as a 1 kHz pulse train. The high time of each pulse comes from a 5-bit duty code. A prescale tick at 32 kHz advances a 32-step phase counter, and one full pass of that counter is one 1 ms dimming period.

The block also has an inactivity timer of its own, which is separate from any system-level idle timers. Each activity strobe loads the timer with a programmed reload count. The timer then counts down once per dimming period. When it runs out, the backlight is forced dark until the next activity strobe arrives. Register decoding is done outside the block, so the duty code, the enable bit and the reload value come in as plain inputs.

Top module: `backlight_dimmer`

## Requirements
- R1: `blOut` is low whenever `panelPower` or `swEnable` is low.
- R2: A latched duty code of 0 holds `blOut` high for the whole period.
- R3: The phase counter advances by one only on a cycle with `tick32k` high, and it wraps from 31 to 0. For a latched duty code d in 1..31, `blOut` is high at phases 0..d-1 and low at phases d..31. That gives d high steps out of 32.
- R4: `dutyCode` is sampled only on the tick that wraps the phase from 31 to 0. A change made in the middle of a period leaves the rest of that period unchanged.
- R5: An activity strobe loads the timer with `idleReload`. The timer counts down by one on each period wrap. On the wrap that takes it from 1 to 0, `blOut` is forced low, and it stays low until the next activity strobe.
- R6: An activity strobe clears the forced-off state, and `blOut` can be high again from the next clock cycle.
- R7: A reload value of 0 disables the cut-off, so the backlight is never forced off.
- R8: After reset the phase is 0, the latched duty code is 0 (solid high) and the timer is not expired. No cut-off can occur until an activity strobe loads the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick32k | input | 1 | One-cycle prescale pulse at 32 kHz; advances the phase |
| panelPower | input | 1 | Panel-power level; gates the output |
| swEnable | input | 1 | Software backlight enable bit; gates the output |
| dutyCode | input | 5 | Dimming code: 0 gives solid high, d gives d/32 high time |
| idleReload | input | TIMER_W (12) | Inactivity timeout in 1 ms periods; 0 disables the timeout |
| activity | input | 1 | Backlight activity strobe; reloads the timer |
| blOut | output | 1 | Backlight control line |

## Verification
The bench walks duty codes that include the extremes 0, 1, 30 and 31. For each code it counts the high steps in a period and checks that they start at phase 0. An off-by-one compare would show up here as 32 or d+1 high steps, or as a code-31 period that stays solid. A duty code is changed in the middle of a period, so a design that fails to latch the code would produce a runt pulse at once. The timer is checked one period before expiry and on the expiry period itself, which catches counting that is early or late. The bench then confirms that a single strobe revives the output, and that a reload value of 0 never cuts the output off, where a wrap-around in the counter would cut it off at once.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int DUTY_W = 5;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic periodWrap;  // last phase step of a period: latch the new duty code
    logic forceOff;    // inactivity timer has run out
  } blStrobe_t;
endpackage

// File: rtl/bl_pwm_ctrl.sv
module bl_pwm_ctrl
  import bl_pwm_pkg::*;
#(
  parameter int TIMER_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick32k,
  input  logic               activity,
  input  logic [TIMER_W-1:0] idleReload,
  output logic [DUTY_W-1:0]  phase,
  output blStrobe_t          strb
);
  localparam logic [DUTY_W-1:0]  PHASE_LAST = '1;
  localparam logic [TIMER_W-1:0] CNT_ONE    = TIMER_W'(1);

  logic [DUTY_W-1:0]  phaseQ;
  logic [TIMER_W-1:0] idleCnt;
  logic               expiredQ;
  logic               wrapNow;

  assign wrapNow = tick32k && (phaseQ == PHASE_LAST);

  // The phase counter steps once per prescale tick.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (tick32k) begin
      phaseQ <= phaseQ + 1'b1;
    end
  end

  // Inactivity timer, counted in whole periods.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt  <= '0;
      expiredQ <= 1'b0;
    end else if (activity) begin
      idleCnt  <= idleReload;
      expiredQ <= 1'b0;
    end else if (wrapNow && (idleCnt != '0)) begin
      idleCnt <= idleCnt - 1'b1;
      if (idleCnt == CNT_ONE) begin
        expiredQ <= 1'b1;
      end
    end
  end

  assign phase           = phaseQ;
  assign strb.periodWrap = wrapNow;
  assign strb.forceOff   = expiredQ;
endmodule

// File: rtl/bl_pwm_dp.sv
module bl_pwm_dp
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  blStrobe_t         strb,
  input  logic [DUTY_W-1:0] phase,
  input  logic [DUTY_W-1:0] dutyCode,
  input  logic              panelPower,
  input  logic              swEnable,
  output logic              blOut
);
  logic [DUTY_W-1:0] dutyLat;
  logic              pwmHigh;

  // The duty code is taken only at a period boundary, so no runt pulses appear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyLat <= '0;
    end else if (strb.periodWrap) begin
      dutyLat <= dutyCode;
    end
  end

  always_comb begin
    pwmHigh = (dutyLat == '0) || (phase < dutyLat);
    blOut   = panelPower && swEnable && !strb.forceOff && pwmHigh;
  end
endmodule

// File: rtl/backlight_dimmer.sv
module backlight_dimmer
  import bl_pwm_pkg::*;
#(
  parameter int TIMER_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick32k,
  input  logic               panelPower,
  input  logic               swEnable,
  input  logic [4:0]         dutyCode,
  input  logic [TIMER_W-1:0] idleReload,
  input  logic               activity,
  output logic               blOut
);
  blStrobe_t         strb;
  logic [DUTY_W-1:0] phase;

  bl_pwm_ctrl #(.TIMER_W(TIMER_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tick32k   (tick32k),
    .activity  (activity),
    .idleReload(idleReload),
    .phase     (phase),
    .strb      (strb)
  );

  bl_pwm_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .phase     (phase),
    .dutyCode  (dutyCode),
    .panelPower(panelPower),
    .swEnable  (swEnable),
    .blOut     (blOut)
  );
endmodule

// File: rtl/backlight_dimmer_chk.sv
module backlight_dimmer_chk
  import bl_pwm_pkg::*;
#(
  parameter int TIMER_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               tick32k,
  input logic               panelPower,
  input logic               swEnable,
  input logic               activity,
  input logic [TIMER_W-1:0] idleReload,
  input logic [DUTY_W-1:0]  phase,
  input blStrobe_t          strb,
  input logic               blOut
);
  assert_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!panelPower || !swEnable) |-> !blOut);

  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !tick32k |=> $stable(phase));

  assert_cutoff_dark_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceOff |-> !blOut);

  assert_cutoff_on_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.forceOff) |-> $past(strb.periodWrap));

  assert_revive_R6: assert property (@(posedge clk) disable iff (!rstN)
    activity |=> !strb.forceOff);

  assert_zero_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
    (activity && (idleReload == '0)) |=> !strb.forceOff);
endmodule

bind backlight_dimmer backlight_dimmer_chk #(.TIMER_W(TIMER_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .tick32k   (tick32k),
  .panelPower(panelPower),
  .swEnable  (swEnable),
  .activity  (activity),
  .idleReload(idleReload),
  .phase     (phase),
  .strb      (strb),
  .blOut     (blOut)
);

// File: tb/backlight_dimmer_tb_top.sv
module backlight_dimmer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 12;
  localparam int NVEC = 6;
  localparam int VEC_DUTY [NVEC] = '{0, 1, 2, 16, 30, 31};
  localparam int VEC_HIGH [NVEC] = '{32, 1, 2, 16, 30, 31};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick32k = 1'b0;
  logic          panelPower = 1'b1;
  logic          swEnable = 1'b1;
  logic [4:0]    dutyCode = 5'd0;
  logic [TW-1:0] idleReload = '0;
  logic          activity = 1'b0;
  logic          blOut;

  int total = 0;
  int bad = 0;
  int benchPhase = 0;
  bit done = 1'b0;

  backlight_dimmer #(.TIMER_W(TW)) dut_i (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .panelPower(panelPower),
    .swEnable(swEnable), .dutyCode(dutyCode), .idleReload(idleReload),
    .activity(activity), .blOut(blOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tickOnce();
    @(negedge clk) tick32k = 1'b1;
    @(negedge clk) tick32k = 1'b0;
    benchPhase = (benchPhase + 1) % 32;
  endtask

  task automatic toPeriodStart();
    do tickOnce(); while (benchPhase != 0);
  endtask

  task automatic pulseActivity();
    @(negedge clk) activity = 1'b1;
    @(negedge clk) activity = 1'b0;
  endtask

  task automatic measure(output int hi, output int lead);
    bit gap = 1'b0;
    hi = 0;
    lead = 0;
    for (int i = 0; i < 32; i++) begin
      if (blOut) begin
        hi++;
        if (!gap) lead++;
      end else begin
        gap = 1'b1;
      end
      tickOnce();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi;
    int lead;
    repeat (3) @(negedge clk);
    check("R8 during reset solid high", int'(blOut), 1);
    rstN = 1'b1;
    dutyCode = 5'd9;
    for (int i = 0; i < 5; i++) tickOnce();
    check("R8 reset duty solid before first wrap", int'(blOut), 1);
    for (int i = 0; i < 40; i++) @(negedge clk);
    check("R8 timer not expired after reset", int'(blOut), 1);

    // Table: each duty code and its high count per period (R2, R3)
    for (int v = 0; v < NVEC; v++) begin
      dutyCode = 5'(VEC_DUTY[v]);
      toPeriodStart();
      measure(hi, lead);
      check($sformatf("R2/R3 duty %0d high steps", VEC_DUTY[v]), hi, VEC_HIGH[v]);
      check($sformatf("R3 duty %0d high from phase 0", VEC_DUTY[v]), lead, VEC_HIGH[v]);
    end

    // R4: a change in the middle of a period waits for the boundary
    dutyCode = 5'd4;
    toPeriodStart();
    for (int i = 0; i < 10; i++) tickOnce();
    dutyCode = 5'd20;
    @(negedge clk);
    check("R4 old duty kept mid-period", int'(blOut), 0);
    toPeriodStart();
    for (int i = 0; i < 10; i++) tickOnce();
    check("R4 new duty next period", int'(blOut), 1);

    // R1: gating by power and enable
    dutyCode = 5'd0;
    toPeriodStart();
    panelPower = 1'b0;
    @(negedge clk);
    check("R1 panel power low", int'(blOut), 0);
    panelPower = 1'b1;
    swEnable = 1'b0;
    @(negedge clk);
    check("R1 enable low", int'(blOut), 0);
    panelPower = 1'b0;
    @(negedge clk);
    check("R1 both low", int'(blOut), 0);
    panelPower = 1'b1;
    swEnable = 1'b1;
    @(negedge clk);
    check("R1 both high", int'(blOut), 1);

    // R5 / R6: timeout after the programmed number of periods
    idleReload = TW'(3);
    pulseActivity();
    toPeriodStart();
    check("R5 lit after 1 period", int'(blOut), 1);
    toPeriodStart();
    check("R5 lit after 2 periods", int'(blOut), 1);
    toPeriodStart();
    check("R5 dark after 3 periods", int'(blOut), 0);
    for (int i = 0; i < 5; i++) tickOnce();
    check("R5 stays dark", int'(blOut), 0);
    pulseActivity();
    check("R6 activity revives", int'(blOut), 1);

    // R7: reload 0 never cuts off
    idleReload = '0;
    pulseActivity();
    for (int p = 0; p < 5; p++) toPeriodStart();
    check("R7 zero reload never expires", int'(blOut), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule